// File: doc/BRIEF.md
# Configurable-Framing Serial Transmitter

This block is the transmit half of an asynchronous serial port. A host writes bytes into a single holding register through a small register port. The block then sends each byte on a serial line as a frame: a low start bit, 5 to 8 data bits with the least significant first, an optional parity bit, and one or two high stop bits. A frame-control register sets the frame format. A 16-bit divisor sets the bit time, which is 16 × divisor clock cycles.

The parity bit can follow the data (odd or even), or it can be held at a fixed 1 or 0 whatever the data. A break bit in the frame-control register pulls the line low for as long as it stays set. A bank bit in the same register swaps the two lowest addresses from the data path to the two divisor bytes, so the divisor is programmed through the same addresses as the data.

Top module: `lcr_uart_tx`

## Requirements
- R1: When frame-control bit 3 is 0, no parity bit is sent, whatever bits 5 and 4 hold.
- R2: Frame-control bits [5:3] = 001 send a parity bit that makes the number of ones in data plus parity odd. Bits [5:3] = 011 make that number even.
- R3: Frame-control bits [5:3] = 101 send a parity bit fixed at 1. Bits [5:3] = 111 send a parity bit fixed at 0.
- R4: Frame-control bits [1:0] = 00, 01, 10 and 11 select 5, 6, 7 and 8 data bits. Bit 2 = 1 selects two stop bits, and bit 2 = 0 selects one.
- R5: The line idles high. A frame is one low start bit, then the data bits with the least significant first, then the parity bit if enabled, then the high stop bits. Every bit lasts 16 × divisor clock cycles.
- R6: Frame-control bit 6 = 1 drives `txd` low in the first cycle after the register write and holds it low until the bit is cleared. A frame in progress is abandoned. A byte still in the holding register is kept, and it is sent once the bit is cleared.
- R7: After reset, the frame-control register and the divisor are 0, `txd` is 1, and both empty flags are 1.
- R8: While frame-control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte, and writes to those addresses leave the holding register untouched. While bit 7 is 0, a write to address 0 loads the holding register. Address 3 holds the frame-control register, and address 2 reads status: bit 0 is `thr_empty` and bit 1 is `tx_empty`.
- R9: While the divisor is 0, no frame starts, `txd` stays 1, and a written byte waits in the holding register.
- R10: `thr_empty` is 0 from the write of a byte until its frame starts. `tx_empty` is 1 only when the holding register is empty and no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational |
| txd | output | 1 | Serial output line |
| thr_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register empty and shifter idle |

## Verification
The bench builds the block with its default parameters: a 16-bit divisor and 16 clocks of oversampling per bit. Most frames run with a divisor of 1, so each bit is exactly 16 cycles long. This allows every framing variant, the break in the middle of a frame and the held byte to be checked within a short run. One frame runs with a divisor of 2, which checks that the bit time scales and that the start of a frame need not line up with the baud tick. The divisor is also set to 0 for a while, to check that transmission stalls.

// File: rtl/lcr_tx_pkg.sv
package lcr_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } tx_state_e;

    // frame-control register, msb first
    typedef struct packed {
        logic       bank;
        logic       brk;
        logic       par_fix;
        logic       par_even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } frame_ctl_t;

    typedef struct packed {
        logic [3:0] nbits;
        logic       par_en;
        logic       par_bit;
        logic       two_stop;
    } frame_cfg_t;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_DIVH = 2'd1;
    localparam logic [1:0] ADR_STAT = 2'd2;
    localparam logic [1:0] ADR_CTL  = 2'd3;

endpackage

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick,
    output logic             div_zero
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } baud_reg_t;

    baud_reg_t r_q, r_d;
    logic [DIV_W-1:0] div_m1;

    always_comb begin
        r_d      = r_q;
        div_zero = (divisor == '0);
        div_m1   = divisor - 1'b1;
        tick     = !div_zero && (r_q.cnt >= div_m1);
        if (div_zero || tick) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    a_r9_no_tick_div0: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !tick);

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import lcr_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  frame_ctl_t        ctl,
    input  logic [DATA_W-1:0] data,
    output frame_cfg_t        cfg
);
    logic [DATA_W-1:0] mask;
    logic              ones_odd;

    always_comb begin
        cfg.nbits    = 4'd5 + {2'b00, ctl.wlen};
        mask         = '0;
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < int'(cfg.nbits));
        end
        ones_odd     = ^(data & mask);
        cfg.par_en   = ctl.par_en;
        cfg.two_stop = ctl.two_stop;
        if (ctl.par_fix) begin
            cfg.par_bit = !ctl.par_even;
        end else if (ctl.par_even) begin
            cfg.par_bit = ones_odd;
        end else begin
            cfg.par_bit = !ones_odd;
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import lcr_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              div_zero,
    input  logic              brk,
    input  logic              hold_valid,
    input  logic [DATA_W-1:0] hold_data,
    input  frame_cfg_t        cfg_in,
    output logic              load,
    output logic              busy,
    output logic              line
);
    localparam int SUB_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVERSAMPLE - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [SUB_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] shreg;
        frame_cfg_t        cfg;
        logic              line;
    } sh_reg_t;

    sh_reg_t r_q, r_d;
    logic    bit_end;

    always_comb begin
        r_d     = r_q;
        load    = 1'b0;
        bit_end = tick && (r_q.sub == SUB_LAST);
        if (tick && r_q.state != ST_IDLE) begin
            r_d.sub = bit_end ? '0 : r_q.sub + 1'b1;
        end
        if (brk) begin
            r_d.state = ST_IDLE;
            r_d.line  = 1'b1;
            r_d.sub   = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    r_d.line = 1'b1;
                    if (hold_valid && !div_zero) begin
                        load       = 1'b1;
                        r_d.state  = ST_START;
                        r_d.line   = 1'b0;
                        r_d.sub    = '0;
                        r_d.shreg  = hold_data;
                        r_d.cfg    = cfg_in;
                    end
                end
                ST_START: begin
                    if (bit_end) begin
                        r_d.state = ST_DATA;
                        r_d.idx   = '0;
                        r_d.line  = r_q.shreg[0];
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        if ({1'b0, r_q.idx} == r_q.cfg.nbits - 4'd1) begin
                            r_d.idx = '0;
                            if (r_q.cfg.par_en) begin
                                r_d.state = ST_PAR;
                                r_d.line  = r_q.cfg.par_bit;
                            end else begin
                                r_d.state = ST_STOP;
                                r_d.line  = 1'b1;
                            end
                        end else begin
                            r_d.idx   = r_q.idx + 1'b1;
                            r_d.shreg = r_q.shreg >> 1;
                            r_d.line  = r_q.shreg[1];
                        end
                    end
                end
                ST_PAR: begin
                    if (bit_end) begin
                        r_d.state = ST_STOP;
                        r_d.idx   = '0;
                        r_d.line  = 1'b1;
                    end
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (r_q.cfg.two_stop && r_q.idx == '0) begin
                            r_d.idx = 1'b1;
                        end else begin
                            r_d.state = ST_IDLE;
                            r_d.idx   = '0;
                        end
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
        busy = (r_q.state != ST_IDLE);
        line = r_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.line  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE) |-> r_q.line);
    a_r6_break_abandons: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> (r_q.state == ST_IDLE));
    a_r9_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (div_zero && r_q.state == ST_IDLE) |=> (r_q.state == ST_IDLE));
    a_r4_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA) |-> ({1'b0, r_q.idx} < r_q.cfg.nbits));

endmodule

// File: rtl/lcr_uart_tx.sv
module lcr_uart_tx
    import lcr_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        txd,
    output logic        thr_empty,
    output logic        tx_empty
);
    localparam int DIVL_W = DIV_W / 2;

    typedef struct packed {
        frame_ctl_t        ctl;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
    } top_reg_t;

    top_reg_t   r_q, r_d;
    logic       tick, div_zero, load, busy, line;
    frame_cfg_t cfg;

    uart_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .divisor  (r_q.div),
        .tick     (tick),
        .div_zero (div_zero)
    );

    uart_tx_framer #(.DATA_W(DATA_W)) u_framer (
        .ctl  (r_q.ctl),
        .data (r_q.hold),
        .cfg  (cfg)
    );

    uart_tx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .div_zero   (div_zero),
        .brk        (r_q.ctl.brk),
        .hold_valid (r_q.hold_full),
        .hold_data  (r_q.hold),
        .cfg_in     (cfg),
        .load       (load),
        .busy       (busy),
        .line       (line)
    );

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.hold_full = 1'b0;
        end
        if (wr_en) begin
            unique case (wr_addr)
                ADR_DATA: begin
                    if (r_q.ctl.bank) begin
                        r_d.div[DIVL_W-1:0] = wr_data[DIVL_W-1:0];
                    end else begin
                        r_d.hold      = wr_data[DATA_W-1:0];
                        r_d.hold_full = 1'b1;
                    end
                end
                ADR_DIVH: begin
                    if (r_q.ctl.bank) begin
                        r_d.div[DIV_W-1:DIVL_W] = wr_data[DIV_W-DIVL_W-1:0];
                    end
                end
                ADR_CTL:  r_d.ctl = frame_ctl_t'(wr_data);
                default:  ;
            endcase
        end
        thr_empty = !r_q.hold_full;
        tx_empty  = !r_q.hold_full && !busy;
        txd       = r_q.ctl.brk ? 1'b0 : line;
        rd_data   = '0;
        unique case (rd_addr)
            ADR_DATA: rd_data = r_q.ctl.bank ? 8'(r_q.div[DIVL_W-1:0]) : 8'h00;
            ADR_DIVH: rd_data = r_q.ctl.bank ? 8'(r_q.div[DIV_W-1:DIVL_W]) : 8'h00;
            ADR_STAT: rd_data = {6'b0, tx_empty, thr_empty};
            default:  rd_data = r_q.ctl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    a_r8_bank_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_DATA && r_q.ctl.bank && !busy && !r_q.hold_full)
            |=> !r_q.hold_full);
    a_r10_empty_order: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> thr_empty);
    a_r6_no_load_in_break: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ctl.brk |-> !load);
    a_r5_load_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && !txd));

endmodule

// File: tb/lcr_uart_tx_test.sv
module lcr_uart_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       txd, thr_empty, tx_empty;

    int n_chk = 0;
    int n_fail = 0;
    int bitlen = 16;
    bit mon_en = 1'b0;
    logic [7:0] cur_ctl = 8'h00;

    logic [15:0] exp_bits[$];
    int          exp_n[$];
    string       exp_tag[$];

    always #5 clk = ~clk;

    lcr_uart_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd3) cur_ctl = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [15:0] frame_of(input logic [7:0] ctl, input logic [7:0] d,
                                             output int n);
        logic [15:0] b;
        int nb;
        logic ones;
        b = '0; nb = 5 + int'(ctl[1:0]); ones = 1'b0;
        n = 1;
        for (int i = 0; i < nb; i++) begin
            b[n] = d[i]; ones ^= d[i]; n++;
        end
        if (ctl[3]) begin
            if (ctl[5]) b[n] = ~ctl[4];
            else        b[n] = ctl[4] ? ones : ~ones;
            n++;
        end
        b[n] = 1'b1; n++;
        if (ctl[2]) begin b[n] = 1'b1; n++; end
        return b;
    endfunction

    task automatic send(input logic [7:0] d, input string tag);
        int n;
        logic [15:0] b;
        while (!thr_empty) @(negedge clk);
        b = frame_of(cur_ctl, d, n);
        exp_bits.push_back(b); exp_n.push_back(n); exp_tag.push_back(tag);
        wr(2'd0, d);
    endtask

    task automatic drain();
        while (exp_n.size() != 0 || !tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // monitor: catches a start edge, samples each bit mid-way, compares with the queue
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (mon_en && prev && !txd) begin
                int n;
                logic [15:0] got, exp;
                string tag;
                got = '0;
                if (exp_n.size() == 0) begin
                    check(1'b0, "R5 unexpected frame", 0, 1);
                    n = 1;
                    exp = '0;
                    tag = "none";
                end else begin
                    n = exp_n.pop_front(); exp = exp_bits.pop_front(); tag = exp_tag.pop_front();
                end
                repeat (bitlen / 2 - 1) @(negedge clk);
                got[0] = txd;
                for (int i = 1; i < n; i++) begin
                    repeat (bitlen) @(negedge clk);
                    got[i] = txd;
                end
                check(got == exp, tag, int'(got), int'(exp));
            end
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit stayed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check(txd == 1'b1, "R7 txd idle", txd, 1);
        check(thr_empty && tx_empty, "R7 empties", {thr_empty, tx_empty}, 3);
        rd(2'd3, v);
        check(v == 8'h00, "R7 ctl reset", v, 0);

        // R8 bank the divisor in, program and read back
        wr(2'd3, 8'h80);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h5A);
        rd(2'd1, v);
        check(v == 8'h5A, "R8 divisor high readback", v, 8'h5A);
        wr(2'd1, 8'h00);
        rd(2'd0, v);
        check(v == 8'h01, "R8 divisor low readback", v, 1);
        check(thr_empty == 1'b1 && txd == 1'b1, "R8 bank write leaves holding reg", thr_empty, 1);
        rd(2'd2, v);
        check(v == 8'h03, "R8 status address", v, 3);

        mon_en = 1'b1;
        bitlen = 16;
        wr(2'd3, 8'h03);
        send(8'hA5, "R5 8N1 frame");
        check(thr_empty == 1'b0, "R10 held after write", thr_empty, 0);
        repeat (20) @(negedge clk);
        check(thr_empty && !tx_empty, "R10 busy flags", {thr_empty, tx_empty}, 2);
        drain();
        check(tx_empty == 1'b1, "R10 empty after frame", tx_empty, 1);

        wr(2'd3, 8'h1A); send(8'h53, "R2 7 bits even parity"); drain();
        wr(2'd3, 8'h0A); send(8'h53, "R2 7 bits odd parity"); drain();
        wr(2'd3, 8'h09); send(8'h2A, "R2 6 bits odd parity"); drain();
        wr(2'd3, 8'h2B); send(8'h00, "R3 mark parity"); drain();
        wr(2'd3, 8'h3B); send(8'hFF, "R3 space parity"); drain();
        wr(2'd3, 8'h04); send(8'hFF, "R4 5 bits two stops"); drain();
        wr(2'd3, 8'h32); send(8'h7F, "R1 parity off with 5:4 set"); drain();
        wr(2'd3, 8'h03); send(8'h11, "R5 back to back a"); send(8'hEE, "R5 back to back b"); drain();

        // R6 break during a frame, held byte survives
        mon_en = 1'b0;
        wr(2'd0, 8'h0F);
        while (txd) @(negedge clk);
        repeat (40) @(negedge clk);
        wr(2'd0, 8'hC3);
        wr(2'd3, 8'h43);
        check(txd == 1'b0, "R6 break immediate", txd, 0);
        check(thr_empty == 1'b0 && tx_empty == 1'b0, "R6 held byte kept", thr_empty, 0);
        stayed = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd) stayed = 1'b0;
        end
        check(stayed, "R6 break held", stayed, 1);
        mon_en = 1'b1;
        cur_ctl = 8'h03;
        begin
            int n; logic [15:0] b;
            b = frame_of(8'h03, 8'hC3, n);
            exp_bits.push_back(b); exp_n.push_back(n); exp_tag.push_back("R6 held byte after break");
        end
        wr(2'd3, 8'h03);
        drain();

        // R9 divisor zero stalls
        wr(2'd3, 8'h83); wr(2'd0, 8'h00); wr(2'd3, 8'h03);
        send(8'h96, "R9 frame after divisor restored");
        stayed = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!txd) stayed = 1'b0;
        end
        check(stayed && !thr_empty, "R9 stalled with byte held", {stayed, thr_empty}, 2);
        bitlen = 32;
        wr(2'd3, 8'h83); wr(2'd0, 8'h02); wr(2'd3, 8'h03);
        drain();

        check(exp_n.size() == 0, "R5 all frames seen", exp_n.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule